// File: doc/BRIEF.md
# Pointer Literal Adjust Unit

This execution unit belongs to a small 8-bit processor core. It keeps three 12-bit data pointers and applies one kind of instruction to them. The instruction adds a 6-bit unsigned literal to a chosen pointer, or subtracts one from it. The decoder ahead of the unit sends it every instruction word with a valid strobe. The unit acts only on words in its own opcode group and treats every other word as a no-op.

A select value of 3 does not address a fourth pointer. It adjusts pointer 2 and also returns from a subroutine. The unit copies the top-of-stack value into its program-counter output, raises a stack pop request for one cycle, and keeps busy high for two cycles. The second cycle is an empty slot, and the unit accepts no instruction during it. For the one-cycle forms, the program-counter output becomes the next word address.

Top module: `ptradj_unit`

## Requirements
- R1: While reset is high and on the cycle after it, all three pointers and the program-counter output are zero and busy and stack pop are low.
- R2: A valid word with bits [15:9] = 1110100 and bit 8 = 0 is an add. Bits [7:6] select pointer 0, 1 or 2 and bits [5:0] hold the literal. The selected pointer equals its old value plus the literal on the cycle after the word is accepted, and the other pointers keep their values.
- R3: The same word with bit 8 = 1 is a subtract. It subtracts the literal from the selected pointer with the same timing as R2.
- R4: Pointer arithmetic wraps modulo 4096 in both directions. For example, 0x015 - 0x16 gives 0xFFF and 0xFFF + 1 gives 0x000.
- R5: When bits [7:6] = 11, pointer 2 is adjusted (add or subtract as set by bit 8). On the cycle after acceptance the program-counter output equals the top-of-stack value that was sampled at acceptance, and stack pop is high for exactly that one cycle.
- R6: A return form keeps busy high for two cycles: the pop cycle and then an empty cycle in which stack pop is low. A valid word presented while busy is high changes no pointer and does not change the program-counter output.
- R7: A one-cycle form leaves busy and stack pop low. On the next cycle the program-counter output equals the program-counter input plus one, wrapping at 21 bits.
- R8: A valid word whose bits [15:9] differ from 1110100 changes no pointer and does not change the program-counter output.
- R9: While valid is low, the pointers and the program-counter output hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| instr_valid | input | 1 | Instruction word is valid this cycle |
| instr_word | input | 16 | Instruction word |
| tos_value | input | 21 | Current top-of-stack return address |
| pc_in | input | 21 | Address of the current instruction |
| ptr0_q | output | 12 | Pointer 0 |
| ptr1_q | output | 12 | Pointer 1 |
| ptr2_q | output | 12 | Pointer 2 |
| stack_pop | output | 1 | One-cycle request to pop the return stack |
| pc_next | output | 21 | Program-counter value produced by the last accepted instruction |
| busy | output | 1 | Return sequence in progress; inputs ignored |

## Verification
Every result is registered once. The pointers, the program-counter output and the first busy/pop cycle all appear on the cycle after the edge that accepts the word. The empty slot of a return follows one cycle later, and busy falls one cycle after that. The bench drives each word on a falling edge, withdraws it on the next falling edge, and reads the outputs there, half a period after the edge that registered them. For the return forms it then reads two more consecutive falling edges to observe the pop cycle, the empty cycle and the release of busy. It also drives a competing word during the busy window.

// File: rtl/ptradj_pkg.sv
package ptradj_pkg;

    // Core dimensions
    localparam int INSTR_W = 16;
    localparam int PTR_W   = 12;
    localparam int PC_W    = 21;
    localparam int LIT_W   = 6;
    localparam int SEL_W   = 2;
    localparam int NUM_PTR = 3;
    localparam int IDX_W   = $clog2(NUM_PTR);

    // Opcode group: upper bits common to add and subtract
    localparam int GRP_W   = INSTR_W - 1 - SEL_W - LIT_W;
    localparam logic [GRP_W-1:0] GRP_CODE = 7'b1110100;
    localparam int SUB_BIT = LIT_W + SEL_W;

    // Select code that means "pointer 2 plus return"
    localparam logic [SEL_W-1:0] SEL_RET = '1;
    localparam logic [IDX_W-1:0] RET_IDX = IDX_W'(2);

    typedef struct packed {
        logic             hit;
        logic             is_sub;
        logic             with_ret;
        logic [IDX_W-1:0] idx;
        logic [LIT_W-1:0] lit;
    } adj_cmd_t;

    typedef enum logic [1:0] {
        SEQ_IDLE = 2'd0,
        SEQ_POP  = 2'd1,
        SEQ_NOP  = 2'd2
    } seq_state_t;

    function automatic logic [PTR_W-1:0] apply_lit(
        input logic [PTR_W-1:0] cur,
        input logic [LIT_W-1:0] lit,
        input logic             is_sub
    );
        logic [PTR_W-1:0] ext;
        ext = {{(PTR_W-LIT_W){1'b0}}, lit};
        return is_sub ? (cur - ext) : (cur + ext);
    endfunction

endpackage

// File: rtl/ptradj_decode.sv
module ptradj_decode
    import ptradj_pkg::*;
(
    input  logic [INSTR_W-1:0] word,
    output adj_cmd_t           cmd
);
    logic [SEL_W-1:0] sel;

    assign sel = word[LIT_W +: SEL_W];

    always_comb begin
        cmd.hit      = (word[INSTR_W-1 -: GRP_W] == GRP_CODE);
        cmd.is_sub   = word[SUB_BIT];
        cmd.with_ret = (sel == SEL_RET);
        cmd.idx      = cmd.with_ret ? RET_IDX : IDX_W'(sel);
        cmd.lit      = word[LIT_W-1:0];
    end
endmodule

// File: rtl/ptradj_alu.sv
module ptradj_alu
    import ptradj_pkg::*;
(
    input  logic [NUM_PTR-1:0][PTR_W-1:0] bank,
    input  adj_cmd_t                      cmd,
    output logic [PTR_W-1:0]              result
);
    logic [PTR_W-1:0] cur;

    always_comb begin
        cur = '0;
        for (int i = 0; i < NUM_PTR; i++) begin
            if (cmd.idx == IDX_W'(i)) cur = bank[i];
        end
        result = apply_lit(cur, cmd.lit, cmd.is_sub);
    end
endmodule

// File: rtl/ptradj_ptrfile.sv
module ptradj_ptrfile
    import ptradj_pkg::*;
(
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          wr_en,
    input  logic [IDX_W-1:0]              wr_idx,
    input  logic [PTR_W-1:0]              wr_data,
    output logic [NUM_PTR-1:0][PTR_W-1:0] bank
);
    for (genvar g = 0; g < NUM_PTR; g++) begin : g_ptr
        logic [PTR_W-1:0] r_q;
        always_ff @(posedge clk) begin
            if (rst) begin
                r_q <= '0;
            end else if (wr_en && (wr_idx == IDX_W'(g))) begin
                r_q <= wr_data;
            end
        end
        assign bank[g] = r_q;
    end
endmodule

// File: rtl/ptradj_retseq.sv
module ptradj_retseq
    import ptradj_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            fire,
    input  logic            with_ret,
    input  logic [PC_W-1:0] tos_value,
    input  logic [PC_W-1:0] pc_in,
    output logic            idle,
    output logic            busy,
    output logic            pop,
    output logic [PC_W-1:0] pc_next
);
    seq_state_t       state_q;
    logic [PC_W-1:0]  pc_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= SEQ_IDLE;
            pc_q    <= '0;
        end else begin
            unique case (state_q)
                SEQ_IDLE: begin
                    if (fire) begin
                        if (with_ret) begin
                            state_q <= SEQ_POP;
                            pc_q    <= tos_value;
                        end else begin
                            pc_q    <= pc_in + PC_W'(1);
                        end
                    end
                end
                SEQ_POP: state_q <= SEQ_NOP;
                SEQ_NOP: state_q <= SEQ_IDLE;
                default: state_q <= SEQ_IDLE;
            endcase
        end
    end

    assign idle    = (state_q == SEQ_IDLE);
    assign busy    = !idle;
    assign pop     = (state_q == SEQ_POP);
    assign pc_next = pc_q;
endmodule

// File: rtl/ptradj_unit.sv
module ptradj_unit
    import ptradj_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               instr_valid,
    input  logic [INSTR_W-1:0] instr_word,
    input  logic [PC_W-1:0]    tos_value,
    input  logic [PC_W-1:0]    pc_in,
    output logic [PTR_W-1:0]   ptr0_q,
    output logic [PTR_W-1:0]   ptr1_q,
    output logic [PTR_W-1:0]   ptr2_q,
    output logic               stack_pop,
    output logic [PC_W-1:0]    pc_next,
    output logic               busy
);
    adj_cmd_t                      cmd;
    logic [NUM_PTR-1:0][PTR_W-1:0] bank;
    logic [PTR_W-1:0]              new_val;
    logic                          seq_idle;
    logic                          fire;

    ptradj_decode u_dec (
        .word (instr_word),
        .cmd  (cmd)
    );

    ptradj_alu u_alu (
        .bank   (bank),
        .cmd    (cmd),
        .result (new_val)
    );

    assign fire = instr_valid && cmd.hit && seq_idle;

    ptradj_ptrfile u_ptrs (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (fire),
        .wr_idx  (cmd.idx),
        .wr_data (new_val),
        .bank    (bank)
    );

    ptradj_retseq u_seq (
        .clk       (clk),
        .rst       (rst),
        .fire      (fire),
        .with_ret  (cmd.with_ret),
        .tos_value (tos_value),
        .pc_in     (pc_in),
        .idle      (seq_idle),
        .busy      (busy),
        .pop       (stack_pop),
        .pc_next   (pc_next)
    );

    assign ptr0_q = bank[0];
    assign ptr1_q = bank[1];
    assign ptr2_q = bank[2];
endmodule

// File: rtl/ptradj_checker.sv
module ptradj_checker
    import ptradj_pkg::*;
(
    input logic               clk,
    input logic               rst,
    input logic               instr_valid,
    input logic [INSTR_W-1:0] instr_word,
    input logic [PTR_W-1:0]   ptr0_q,
    input logic [PTR_W-1:0]   ptr1_q,
    input logic [PTR_W-1:0]   ptr2_q,
    input logic               stack_pop,
    input logic [PC_W-1:0]    pc_next,
    input logic               busy
);
    // R5: a pop request only occurs inside a busy window
    p_pop_in_busy_r5: assert property (@(posedge clk) disable iff (rst)
        stack_pop |-> busy);

    // R5 / R6: pop lasts one cycle and is followed by a busy empty slot
    p_pop_then_nop_r6: assert property (@(posedge clk) disable iff (rst)
        stack_pop |=> (busy && !stack_pop));

    // R6: the empty slot ends the busy window
    p_busy_bounded_r6: assert property (@(posedge clk) disable iff (rst)
        (busy && !stack_pop) |=> !busy);

    // R6: busy always starts with the pop cycle
    p_busy_starts_pop_r6: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> stack_pop);

    // R6: nothing is accepted while busy
    p_busy_ignores_r6: assert property (@(posedge clk) disable iff (rst)
        busy |=> ($stable(ptr0_q) && $stable(ptr1_q) && $stable(ptr2_q)
                  && $stable(pc_next)));

    // R8: words outside the opcode group leave state untouched
    p_foreign_word_r8: assert property (@(posedge clk) disable iff (rst)
        (instr_valid && (instr_word[INSTR_W-1 -: GRP_W] != GRP_CODE))
        |=> ($stable(ptr0_q) && $stable(ptr1_q) && $stable(ptr2_q)
             && $stable(pc_next)));

    // R9: no valid word, no change
    p_hold_idle_r9: assert property (@(posedge clk) disable iff (rst)
        !instr_valid |=> ($stable(ptr0_q) && $stable(ptr1_q) && $stable(ptr2_q)
                          && $stable(pc_next)));

    // R1: reset clears the outputs
    p_reset_clear_r1: assert property (@(posedge clk)
        rst |=> (ptr0_q == '0 && ptr1_q == '0 && ptr2_q == '0
                 && pc_next == '0 && !busy && !stack_pop));
endmodule

bind ptradj_unit ptradj_checker u_chk (
    .clk         (clk),
    .rst         (rst),
    .instr_valid (instr_valid),
    .instr_word  (instr_word),
    .ptr0_q      (ptr0_q),
    .ptr1_q      (ptr1_q),
    .ptr2_q      (ptr2_q),
    .stack_pop   (stack_pop),
    .pc_next     (pc_next),
    .busy        (busy)
);

// File: tb/tb_ptradj_unit.sv
`timescale 1ns/1ps
module tb_ptradj_unit;
    logic        clk = 1'b0;
    logic        rst;
    logic        instr_valid;
    logic [15:0] instr_word;
    logic [20:0] tos_value;
    logic [20:0] pc_in;
    logic [11:0] ptr0_q, ptr1_q, ptr2_q;
    logic        stack_pop;
    logic [20:0] pc_next;
    logic        busy;

    int n_checks = 0;
    int n_errors = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    ptradj_unit dut (
        .clk(clk), .rst(rst), .instr_valid(instr_valid), .instr_word(instr_word),
        .tos_value(tos_value), .pc_in(pc_in), .ptr0_q(ptr0_q), .ptr1_q(ptr1_q),
        .ptr2_q(ptr2_q), .stack_pop(stack_pop), .pc_next(pc_next), .busy(busy)
    );

    typedef struct packed {
        logic [15:0] word;
        logic [20:0] pc;
        logic [11:0] e0;
        logic [11:0] e1;
        logic [11:0] e2;
        logic [20:0] epc;
    } vec_t;

    // Applied in order after reset, all pointers starting at zero
    localparam vec_t VEC [0:7] = '{
        '{16'hE83F, 21'h000100, 12'h03F, 12'h000, 12'h000, 21'h000101}, // R2 add p0
        '{16'hE855, 21'h000200, 12'h03F, 12'h015, 12'h000, 21'h000201}, // R2 add p1
        '{16'hE93F, 21'h000300, 12'h000, 12'h015, 12'h000, 21'h000301}, // R3 sub p0
        '{16'hE956, 21'h000400, 12'h000, 12'hFFF, 12'h000, 21'h000401}, // R4 underflow
        '{16'hE8A0, 21'h1FFFFF, 12'h000, 12'hFFF, 12'h020, 21'h000000}, // R7 pc wrap
        '{16'hEA00, 21'h000777, 12'h000, 12'hFFF, 12'h020, 21'h000000}, // R8 foreign
        '{16'hE841, 21'h000555, 12'h000, 12'h000, 12'h020, 21'h000556}, // R4 overflow
        '{16'hD8C1, 21'h000999, 12'h000, 12'h000, 12'h020, 21'h000556}  // R8 foreign
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // Drive a word for one edge; returns at the following falling edge
    task automatic issue(input logic [15:0] w, input logic [20:0] pc, input logic [20:0] tos);
        @(negedge clk);
        instr_valid = 1'b1;
        instr_word  = w;
        pc_in       = pc;
        tos_value   = tos;
        @(negedge clk);
        instr_valid = 1'b0;
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        rst = 1'b1; instr_valid = 1'b0; instr_word = '0; tos_value = '0; pc_in = '0;
        repeat (3) @(negedge clk);
        check("R1 ptr0", 32'(ptr0_q), 0);
        check("R1 ptr1", 32'(ptr1_q), 0);
        check("R1 ptr2", 32'(ptr2_q), 0);
        check("R1 pc", 32'(pc_next), 0);
        check("R1 busy", 32'(busy), 0);
        check("R1 pop", 32'(stack_pop), 0);
        rst = 1'b0;

        // Table walk
        for (int i = 0; i < 8; i++) begin
            issue(VEC[i].word, VEC[i].pc, 21'h0ABCDE & 21'h1FFFFF);
            check($sformatf("R2/R3/R4/R8 vec%0d ptr0", i), 32'(ptr0_q), 32'(VEC[i].e0));
            check($sformatf("R2/R3/R4/R8 vec%0d ptr1", i), 32'(ptr1_q), 32'(VEC[i].e1));
            check($sformatf("R2/R3/R4/R8 vec%0d ptr2", i), 32'(ptr2_q), 32'(VEC[i].e2));
            check($sformatf("R7/R8 vec%0d pc", i), 32'(pc_next), 32'(VEC[i].epc));
            check($sformatf("R7 vec%0d busy", i), 32'(busy), 0);
            check($sformatf("R7 vec%0d pop", i), 32'(stack_pop), 0);
        end

        // R9: word present but valid low
        @(negedge clk);
        instr_word = 16'hE805;
        pc_in = 21'h000042;
        @(negedge clk);
        @(negedge clk);
        check("R9 ptr0 hold", 32'(ptr0_q), 0);
        check("R9 pc hold", 32'(pc_next), 32'h556);

        // Directed: build ptr2 = 0x3FF from a fresh reset
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        for (int i = 0; i < 16; i++) issue(16'hE8BF, 21'h10, 21'h0);
        issue(16'hE88F, 21'h10, 21'h0);
        check("R2 ptr2 build", 32'(ptr2_q), 32'h3FF);
        issue(16'hE8A3, 21'h10, 21'h0);
        check("R2 ptr2 add 23h", 32'(ptr2_q), 32'h422);
        issue(16'hE9A3, 21'h10, 21'h0);
        check("R3 ptr2 sub 23h", 32'(ptr2_q), 32'h3FF);

        // R5: subtract-with-return
        issue(16'hE9E3, 21'h10, 21'h012345);
        check("R5 ptr2", 32'(ptr2_q), 32'h3DC);
        check("R5 pc", 32'(pc_next), 32'h012345);
        check("R5 pop", 32'(stack_pop), 1);
        check("R5 busy", 32'(busy), 1);
        check("R5 ptr0 untouched", 32'(ptr0_q), 0);
        // R6: competing word during busy
        instr_valid = 1'b1; instr_word = 16'hE805; tos_value = 21'h000777; pc_in = 21'h20;
        @(negedge clk);
        check("R6 busy nop cycle", 32'(busy), 1);
        check("R6 pop low", 32'(stack_pop), 0);
        check("R6 ptr0 ignored", 32'(ptr0_q), 0);
        check("R6 pc kept", 32'(pc_next), 32'h012345);
        instr_valid = 1'b0;
        @(negedge clk);
        check("R6 busy released", 32'(busy), 0);
        check("R6 ptr0 still", 32'(ptr0_q), 0);
        check("R6 pc still", 32'(pc_next), 32'h012345);

        // R5: add-with-return
        issue(16'hE8E3, 21'h10, 21'h00ABCD);
        check("R5 add ret ptr2", 32'(ptr2_q), 32'h3FF);
        check("R5 add ret pc", 32'(pc_next), 32'h00ABCD);
        check("R5 add ret pop", 32'(stack_pop), 1);
        @(negedge clk);
        @(negedge clk);
        check("R6 idle again", 32'(busy), 0);

        // R1: reset during a return
        issue(16'hE9C1, 21'h10, 21'h000055);
        rst = 1'b1;
        @(negedge clk);
        check("R1 mid ptr2", 32'(ptr2_q), 0);
        check("R1 mid busy", 32'(busy), 0);
        check("R1 mid pop", 32'(stack_pop), 0);
        check("R1 mid pc", 32'(pc_next), 0);
        rst = 1'b0;
        @(negedge clk);
        finish_run();
    end
endmodule